// File: doc/BRIEF.md
# Paged Microcode Register Window

This block is the word-access slave that sits in front of a programmable vector unit. It splits a 10-bit word address space into three regions. The first is a bank of twelve control and status words. The second is a window onto the 128-entry general register file. The third is a 512-word window onto a 2048-word microcode store.

The microcode store is too large to map flat, so it is bank-switched. A page register selects which of the four 512-word pages the window reaches, and software changes pages by writing that register before touching the window. Writing the control word with its start bit set does not store anything; it emits a single-cycle start strobe for the sequencer.

Every request is accepted in the cycle it is presented. Its response follows exactly one cycle later. Addresses that fall outside the three regions are flagged with an error on the response.

Top module: `ucode_window`

## Requirements
- R1: Word addresses 0x001 to 0x00B are 32-bit read/write registers, and each read returns the last value written there. Address 0x004 is the exception described in R5. The roles of these registers, in address order, are: mesh base, horizontal last, vertical last, code page, vertex count, collisions, stray writes, last DMA, program counter, data-register base and code base.
- R2: Word address 0x000 is the control word.
  - A write with bit 0 set raises start_o for exactly one cycle, in the response cycle of that write.
  - A write with bit 0 clear raises nothing.
  - Writes to this word store nothing, and reads of it always return zero.
- R3: Word addresses 0x100 to 0x17F read and write general register (address − 0x100).
- R4: Word addresses 0x200 to 0x3FF read and write microcode word 512 × page + (address − 0x200). The store holds 2048 words, and each page keeps its own contents.
- R5: The page register at word address 0x004 keeps only bits 1:0 of a written value. It reads back as that masked value, so writing 7 selects page 3 and writing 5 selects page 1.
- R6: Unmapped addresses are 0x00C to 0x0FF and 0x180 to 0x1FF.
  - A read of an unmapped address returns zero.
  - A write to an unmapped address changes no state.
  - Either access raises err_o for one cycle, in its response cycle.
- R7: The access timing is fixed.
  - req_ready_o is always high.
  - Every accepted request yields rsp_valid_o exactly one cycle later, and no response appears without a request.
  - Read data shows the state before that same cycle's write.
  - A write response carries zero data.
  - err_o and start_o appear only together with rsp_valid_o.
- R8: Reset clears every status register, every general register and every microcode word to zero. It also drives rsp_valid_o, err_o and start_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (constant high) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data; zero for writes and errors |
| err_o | output | 1 | Unmapped address, valid with the response |
| start_o | output | 1 | One-cycle start strobe to the sequencer |

## Verification
The bench writes distinct values at offsets 0 and 511 of all four pages, then reads them back after switching pages. A window that ignored the page, or one that wrapped pages, would return another page's word. It writes page values above 3 and checks that they read back masked, which catches a page register that stores the full word or drops bit 1. Writes to both edges of each unmapped hole are followed by reads of the mapped neighbours, which shows whether a stray write leaked into the register file. Back-to-back traffic, with a write to the control word beside a read of the control word, shows whether start was delayed, was stored as a value, or whether read data was returned after the same cycle's write.

// File: rtl/ucw_pkg.sv
package ucw_pkg;
  typedef enum logic [1:0] {
    RG_CSR  = 2'd0,
    RG_GPR  = 2'd1,
    RG_UC   = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/ucw_decode.sv
module ucw_decode
  import ucw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned CSR_N    = 12,
  parameter int unsigned GPR_BASE = 256,
  parameter int unsigned GPR_N    = 128,
  parameter int unsigned UC_BASE  = 512,
  parameter int unsigned UC_WIN   = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam logic [ADDR_W-1:0] CSR_END = ADDR_W'(CSR_N);
  localparam logic [ADDR_W-1:0] GPR_LO  = ADDR_W'(GPR_BASE);
  localparam logic [ADDR_W-1:0] GPR_HI  = ADDR_W'(GPR_BASE + GPR_N);
  localparam logic [ADDR_W-1:0] UC_LO   = ADDR_W'(UC_BASE);
  localparam int unsigned       UC_TOP  = UC_BASE + UC_WIN;

  always_comb begin
    region_o = RG_NONE;
    offset_o = '0;
    if (addr_i < CSR_END) begin
      region_o = RG_CSR;
      offset_o = addr_i;
    end else if (addr_i >= GPR_LO && addr_i < GPR_HI) begin
      region_o = RG_GPR;
      offset_o = addr_i - GPR_LO;
    end else if (addr_i >= UC_LO && 32'(addr_i) < UC_TOP) begin
      region_o = RG_UC;
      offset_o = addr_i - UC_LO;
    end
  end
endmodule

// File: rtl/ucw_store.sv
module ucw_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= (acc_i && !we_i) ? mem_q[idx_i] : '0;
      if (acc_i && we_i) mem_q[idx_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ucw_csr_bank.sv
module ucw_csr_bank #(
  parameter int unsigned CSR_N     = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_W    = 2,
  parameter int unsigned CTL_IDX   = 0,
  parameter int unsigned PAGE_IDX  = 4,
  parameter int unsigned START_BIT = 0,
  localparam int unsigned IDX_W    = $clog2(CSR_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              start_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [DATA_W-1:0] csr_q [CSR_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CSR_N; i++) csr_q[i] <= '0;
      rdata_o <= '0;
      start_o <= 1'b0;
    end else begin
      rdata_o <= (acc_i && !we_i) ? csr_q[idx_i] : '0;
      start_o <= acc_i && we_i && (idx_i == IDX_W'(CTL_IDX)) && wdata_i[START_BIT];
      for (int i = 0; i < CSR_N; i++) begin
        if (acc_i && we_i && idx_i == IDX_W'(i)) begin
          if (i == PAGE_IDX)     csr_q[i] <= DATA_W'(wdata_i[PAGE_W-1:0]);
          else if (i != CTL_IDX) csr_q[i] <= wdata_i;
        end
      end
    end
  end

  assign page_o = csr_q[PAGE_IDX][PAGE_W-1:0];

  AST_CTL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && idx_i == IDX_W'(CTL_IDX)) |=> rdata_o == '0); // R2
  AST_PAGE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i && idx_i == IDX_W'(PAGE_IDX)) |=> page_o == $past(wdata_i[PAGE_W-1:0])); // R5
endmodule

// File: rtl/ucode_window.sv
module ucode_window
  import ucw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CSR_N    = 12,
  parameter int unsigned GPR_BASE = 256,
  parameter int unsigned GPR_N    = 128,
  parameter int unsigned UC_BASE  = 512,
  parameter int unsigned UC_WIN   = 512,
  parameter int unsigned UC_PAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o,
  output logic              start_o
);
  localparam int unsigned CSR_IW = $clog2(CSR_N);
  localparam int unsigned GPR_IW = $clog2(GPR_N);
  localparam int unsigned PAGE_W = $clog2(UC_PAGES);
  localparam int unsigned OFF_W  = $clog2(UC_WIN);
  localparam int unsigned UC_DEP = UC_WIN * UC_PAGES;
  localparam int unsigned UC_IW  = PAGE_W + OFF_W;

  region_e           region;
  logic [ADDR_W-1:0] offset;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] csr_rd, gpr_rd, uc_rd;
  region_e           rsp_region_q;
  logic              acc_csr, acc_gpr, acc_uc;

  assign req_ready_o = 1'b1;

  ucw_decode #(
    .ADDR_W(ADDR_W), .CSR_N(CSR_N), .GPR_BASE(GPR_BASE), .GPR_N(GPR_N),
    .UC_BASE(UC_BASE), .UC_WIN(UC_WIN)
  ) u_decode (
    .addr_i(req_addr_i), .region_o(region), .offset_o(offset)
  );

  assign acc_csr = req_valid_i && region == RG_CSR;
  assign acc_gpr = req_valid_i && region == RG_GPR;
  assign acc_uc  = req_valid_i && region == RG_UC;

  ucw_csr_bank #(
    .CSR_N(CSR_N), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_csr (
    .clk_i, .rst_ni, .acc_i(acc_csr), .we_i(req_we_i),
    .idx_i(offset[CSR_IW-1:0]), .wdata_i(req_wdata_i),
    .rdata_o(csr_rd), .start_o(start_o), .page_o(page)
  );

  ucw_store #(.DEPTH(GPR_N), .DATA_W(DATA_W)) u_gpr (
    .clk_i, .rst_ni, .acc_i(acc_gpr), .we_i(req_we_i),
    .idx_i(offset[GPR_IW-1:0]), .wdata_i(req_wdata_i), .rdata_o(gpr_rd)
  );

  // window offset concatenated under the page: bank switch, no adder
  ucw_store #(.DEPTH(UC_DEP), .DATA_W(DATA_W)) u_ucode (
    .clk_i, .rst_ni, .acc_i(acc_uc), .we_i(req_we_i),
    .idx_i(UC_IW'({page, offset[OFF_W-1:0]})), .wdata_i(req_wdata_i), .rdata_o(uc_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      err_o        <= 1'b0;
      rsp_region_q <= RG_NONE;
    end else begin
      rsp_valid_o  <= req_valid_i;
      err_o        <= req_valid_i && region == RG_NONE;
      rsp_region_q <= region;
    end
  end

  always_comb begin
    unique case (rsp_region_q)
      RG_CSR:  rsp_rdata_o = csr_rd;
      RG_GPR:  rsp_rdata_o = gpr_rd;
      RG_UC:   rsp_rdata_o = uc_rd;
      default: rsp_rdata_o = '0;
    endcase
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R7
  AST_ERR_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_rdata_o == '0); // R6
  AST_WR_RSP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i) |=> rsp_rdata_o == '0); // R7
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> rsp_valid_o && $past(req_we_i && req_addr_i == '0 && req_wdata_i[0])); // R2
endmodule

// File: tb/ucode_window_bench.sv
`timescale 1ns/1ps
module ucode_window_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [9:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        err_o;
  logic        start_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit r8_phase = 0;

  always #2.5 clk_i = ~clk_i;

  ucode_window u_ucode_window (.*);

  // behavioural reference
  logic [31:0] csr_m [12];
  logic [31:0] gpr_m [128];
  logic [31:0] uc_m  [2048];
  logic        exp_valid = 0, exp_err = 0, exp_start = 0;
  logic [31:0] exp_data = 0;
  string       exp_tag = "R7";

  function automatic string tag_of(logic [9:0] a);
    if (a == 0) return "R2";
    if (a == 4) return "R5";
    if (a < 12) return "R1";
    if (a >= 10'h100 && a < 10'h180) return "R3";
    if (a >= 10'h200) return "R4";
    return "R6";
  endfunction

  initial begin
    for (int i = 0; i < 12; i++) csr_m[i] = 0;
    for (int i = 0; i < 128; i++) gpr_m[i] = 0;
    for (int i = 0; i < 2048; i++) uc_m[i] = 0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      exp_valid = 0; exp_err = 0; exp_start = 0; exp_data = 0; exp_tag = "R8";
    end else if (req_valid_i) begin
      int a, ui;
      a = int'(req_addr_i);
      ui = int'(csr_m[4] % 4) * 512 + (a - 512);
      exp_valid = 1;
      exp_err = 0;
      exp_start = 0;
      exp_data = 0;
      exp_tag = r8_phase ? "R8" : tag_of(req_addr_i);
      if (a < 12) begin
        if (!req_we_i) exp_data = (a == 0) ? 0 : csr_m[a];
        else if (a == 0) exp_start = req_wdata_i[0];
        else if (a == 4) csr_m[4] = req_wdata_i & 32'h3;
        else csr_m[a] = req_wdata_i;
      end else if (a >= 256 && a < 384) begin
        if (req_we_i) gpr_m[a-256] = req_wdata_i; else exp_data = gpr_m[a-256];
      end else if (a >= 512) begin
        if (req_we_i) uc_m[ui] = req_wdata_i; else exp_data = uc_m[ui];
      end else begin
        exp_err = 1;
      end
    end else begin
      exp_valid = 0; exp_err = 0; exp_start = 0; exp_data = 0; exp_tag = "R7";
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (rsp_valid_o !== exp_valid || err_o !== exp_err || start_o !== exp_start ||
          rsp_rdata_o !== exp_data || req_ready_o !== 1'b1) begin
        failures++;
        $display("FAIL %s: valid=%b err=%b start=%b data=%h rdy=%b expected valid=%b err=%b start=%b data=%h rdy=1",
                 exp_tag, rsp_valid_o, err_o, start_o, rsp_rdata_o, req_ready_o,
                 exp_valid, exp_err, exp_start, exp_data);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = 0; req_addr_i = a; req_wdata_i = 32'hdead_beef;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_valid_i = 0; req_we_i = 0;
    end
  endtask

  initial begin
    // R8: outputs low while held in reset
    repeat (3) @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 0 || err_o !== 0 || start_o !== 0) begin
      failures++;
      $display("FAIL R8: valid=%b err=%b start=%b expected 0 0 0", rsp_valid_o, err_o, start_o);
    end
    rst_ni = 1;
    idle(2);
    // R8: state cleared after reset
    r8_phase = 1;
    rd(10'h001); rd(10'h004); rd(10'h00B); rd(10'h100); rd(10'h17F);
    rd(10'h200); rd(10'h3FF);
    idle(1);
    r8_phase = 0;
    // R1: plain registers
    for (int i = 1; i < 12; i++) if (i != 4) wr(10'(i), 32'hA500_0000 + 32'(i * 17));
    for (int i = 1; i < 12; i++) rd(10'(i));
    idle(2);
    // R2: start strobe, not stored
    wr(10'h000, 32'h0000_0001); rd(10'h000); wr(10'h000, 32'hFFFF_FFFE); rd(10'h000);
    wr(10'h000, 32'h8000_0003); wr(10'h000, 32'h1); idle(1);
    // R5: page masking
    wr(10'h004, 32'h7); rd(10'h004); wr(10'h004, 32'hFFFF_FFF5); rd(10'h004); idle(1);
    // R3: register file window
    wr(10'h100, 32'h1111_0000); wr(10'h17F, 32'h2222_007F); wr(10'h140, 32'h3333_0040);
    rd(10'h100); rd(10'h17F); rd(10'h140); rd(10'h101);
    wr(10'h101, 32'h4444_0001); rd(10'h101); idle(1);
    // R4: each page holds its own words at both window edges
    for (int p = 0; p < 4; p++) begin
      wr(10'h004, 32'(p));
      wr(10'h200, 32'hC0DE_0000 + 32'(p));
      wr(10'h3FF, 32'hC0DE_F000 + 32'(p));
      wr(10'h2AA, 32'hC0DE_A000 + 32'(p));
    end
    for (int p = 3; p >= 0; p--) begin
      wr(10'h004, 32'(p) | 32'h100);
      rd(10'h200); rd(10'h3FF); rd(10'h2AA);
    end
    wr(10'h004, 32'h6); rd(10'h3FF); idle(2);
    // R6: unmapped holes, writes harmless
    wr(10'h00C, 32'hBAD0_0001); wr(10'h0FF, 32'hBAD0_0002);
    wr(10'h180, 32'hBAD0_0003); wr(10'h1FF, 32'hBAD0_0004);
    rd(10'h00C); rd(10'h0FF); rd(10'h180); rd(10'h1FF);
    rd(10'h00B); rd(10'h17F); rd(10'h100); rd(10'h001);
    idle(1);
    // R7: read returns pre-write state when interleaved back to back
    wr(10'h105, 32'h5555_5555); rd(10'h105); wr(10'h105, 32'h6666_6666); rd(10'h105);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL R7: watchdog expired, actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule